// File: doc/BRIEF.md
# Page Walk Step Unit

This block carries out a single step of a page-table walk that software sequences one instruction at a time. It has two operations. A directory step takes a table base and a level from 1 to 4. It reads one 64-bit word from memory and returns it as the base of the next level down. A leaf step takes a table base and an even/odd selector. It produces one half of a translation-cache refill pair, together with the page size of the mapping.

The index into each table comes from the faulting virtual address. Each level's bit position and index width, and the size of a table entry, come from two configuration words. Huge-page entries never reach memory. A directory step returns them tagged with the level at which they were found. A leaf step turns them into an even or odd half-page entry whose page size is derived from that level. Memory is reached through a single-beat read port, with at most one read outstanding.

Top module: `pgw_step_unit`

## Requirements
- R1: While reset is held low, busy, done, mem_req_valid, dir_result, even_entry, odd_entry and leaf_ps are all zero.
- R2: The configuration word layout is as follows. cfg_lo holds the leaf table position [5:0] and width [10:6], level 1 position [16:11] and width [21:17], and level 2 position [27:22] and width [32:28]. cfg_hi holds level 3 position [5:0] and width [10:6], level 4 position [16:11] and width [21:17], and the entry size code [23:22]. A directory step at level L reads address (base & PAMASK) | (((fault_va >> posL) & (2^widthL - 1)) << shift). PAMASK keeps the low PA_W bits.
- R3: The index shift is (code+1)*3, for entry size code 0, 1, 2 or 3.
- R4: A directory step with level 0 or a level above 4 makes no memory read. It returns req_base unchanged, and done follows one cycle after acceptance.
- R5: A directory step whose base has bit 6 (huge) set makes no read. If the 2-bit level field [14:13] is nonzero, the base is returned unchanged. Otherwise the base is returned with req_level[1:0] written into that field.
- R6: A leaf step on a normal table clears bit 0 of the table index. The even half is read at index<<shift and the odd half at (index+1)<<shift. leaf_ps reports the leaf table position.
- R7: A leaf step on a huge entry makes no read. It clears the level field and bit 6. If bit 12 (huge-global) is set, bit 12 is cleared and bit 6 (global) is set. leaf_ps is pos+width-1 of the level named in the field, with field 0 selecting the leaf table geometry.
- R8: For the odd half of a huge entry, 2^leaf_ps is added to the transformed entry. The even half is the transformed entry itself.
- R9: The base used for reads and leaf results, and every word returned by memory, is masked to PA_W bits. A memory address never has bits set at or above PA_W.
- R10: A directory step updates only dir_result. A leaf step updates leaf_ps and only the half (even_entry or odd_entry) that req_odd selects.
- R11: mem_req_valid is a single-cycle pulse, and only one read is outstanding at a time. Requests made while busy is high are ignored. done pulses in the cycle after the response is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a step (taken only while busy is low) |
| req_leaf | input | 1 | 0 = directory step, 1 = leaf step |
| req_base | input | 64 | Table base or huge entry |
| req_level | input | 3 | Directory level |
| req_odd | input | 1 | Leaf half selector (1 = odd) |
| fault_va | input | 64 | Faulting virtual address |
| cfg_lo | input | 33 | Leaf, level 1 and level 2 geometry |
| cfg_hi | input | 24 | Level 3 and level 4 geometry, entry size code |
| busy | output | 1 | A memory read is in flight |
| done | output | 1 | One-cycle completion pulse |
| dir_result | output | 64 | Result of the last directory step |
| even_entry | output | 64 | Last even refill half |
| odd_entry | output | 64 | Last odd refill half |
| leaf_ps | output | 7 | Page size of the last leaf step |
| mem_req_valid | output | 1 | Read request pulse |
| mem_req_addr | output | 64 | Read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |

## Verification
A wrong destination tag or a stale state register shows up at the done pulse. The step's value lands in the wrong one of dir_result, even_entry or odd_entry, or a later step hangs with busy stuck high. Address arithmetic errors in index extraction, bit-0 clearing or shift selection are visible one cycle after acceptance, on mem_req_addr. Huge-entry transform errors appear in the result registers one cycle after acceptance, with no read pulse at all. The scoreboard compares every address and every result register on each completion, including the registers that should have kept their old value.

// File: rtl/pgw_pkg.sv
// pgw_pkg: shared types and entry bit positions for the page walk step unit.
// Assumes 64-bit table entries; bit positions are the ones the walker decodes.
package pgw_pkg;
    localparam int HUGE_BIT = 6;   // huge flag in a directory entry
    localparam int GLB_BIT  = 6;   // global flag in a leaf entry
    localparam int HGLB_BIT = 12;  // global flag carried by a huge entry
    localparam int LVL_LSB  = 13;  // level tag field, 2 bits
    localparam int LVL_W    = 2;

    typedef struct packed {
        logic [5:0] pos;
        logic [4:0] width;
    } geom_t;

    typedef enum logic {ST_IDLE, ST_WAIT} state_t;
    typedef enum logic [1:0] {DST_DIR, DST_EVEN, DST_ODD} dest_t;
endpackage

// File: rtl/pgw_geom_sel.sv
// pgw_geom_sel: picks the bit position and index width for one table level.
// Levels 1-2 come from the low word, 3-4 from the high word; any other value
// selects the leaf table geometry. Purely combinational.
module pgw_geom_sel
    import pgw_pkg::*;
(
    input  logic [32:0] cfg_lo,
    input  logic [23:0] cfg_hi,
    input  logic [2:0]  level,
    output geom_t       geom,
    output logic [1:0]  size_code
);
    // level decode onto configuration fields
    always_comb begin
        case (level)
            3'd1:    geom = '{pos: cfg_lo[16:11], width: cfg_lo[21:17]};
            3'd2:    geom = '{pos: cfg_lo[27:22], width: cfg_lo[32:28]};
            3'd3:    geom = '{pos: cfg_hi[5:0],   width: cfg_hi[10:6]};
            3'd4:    geom = '{pos: cfg_hi[16:11], width: cfg_hi[21:17]};
            default: geom = '{pos: cfg_lo[5:0],   width: cfg_lo[10:6]};
        endcase
    end

    assign size_code = cfg_hi[23:22];
endmodule

// File: rtl/pgw_addr_gen.sv
// pgw_addr_gen: forms the memory address of a table entry from the masked
// base, the faulting address and the level geometry. Leaf steps pair entries:
// index bit 0 is dropped and the odd half uses the next slot. Combinational.
module pgw_addr_gen
    import pgw_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic [DW-1:0] base_m,
    input  logic [DW-1:0] fault_va,
    input  geom_t         geom,
    input  logic [1:0]    size_code,
    input  logic          is_leaf,
    input  logic          odd,
    output logic [DW-1:0] addr
);
    logic [DW-1:0] idx_mask;
    logic [DW-1:0] idx_raw;
    logic [DW-1:0] idx_sel;
    logic [3:0]    shift;

    // index extraction, pairing and scaling by entry size
    always_comb begin
        idx_mask = (DW'(1) << geom.width) - DW'(1);
        idx_raw  = (fault_va >> geom.pos) & idx_mask;
        idx_sel  = idx_raw;
        if (is_leaf) begin
            idx_sel = {idx_raw[DW-1:1], 1'b0} + DW'(odd);
        end
        shift = ({2'b00, size_code} + 4'd1) * 4'd3;
        addr  = base_m | (idx_sel << shift);
    end
endmodule

// File: rtl/pgw_huge_xform.sv
// pgw_huge_xform: handles huge entries without touching memory. For a
// directory step it tags the entry with its level; for a leaf step it strips
// the huge markers, moves the huge-global flag and splits into halves.
module pgw_huge_xform
    import pgw_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic [DW-1:0] base_raw,
    input  logic [DW-1:0] base_m,
    input  logic [2:0]    req_level,
    input  geom_t         geom,
    input  logic          odd,
    output logic [DW-1:0] dir_tagged,
    output logic [DW-1:0] leaf_val,
    output logic [6:0]    leaf_ps
);
    logic [DW-1:0] stripped;

    // directory tagging: keep an existing level, else record the request
    always_comb begin
        dir_tagged = base_raw;
        if (base_raw[LVL_LSB +: LVL_W] == '0) begin
            dir_tagged[LVL_LSB +: LVL_W] = req_level[LVL_W-1:0];
        end
    end

    // leaf split: clear markers, relocate global flag, add half size if odd
    always_comb begin
        stripped = base_m;
        stripped[LVL_LSB +: LVL_W] = '0;
        stripped[HUGE_BIT] = 1'b0;
        if (base_m[HGLB_BIT]) begin
            stripped[HGLB_BIT] = 1'b0;
            stripped[GLB_BIT]  = 1'b1;
        end
        leaf_ps  = {1'b0, geom.pos} + {2'b00, geom.width} - 7'd1;
        leaf_val = odd ? (stripped + (DW'(1) << leaf_ps)) : stripped;
    end
endmodule

// File: rtl/pgw_step_unit.sv
// pgw_step_unit: one directory or leaf step of a software-driven page walk.
// Assumes memory answers each request pulse with exactly one response at
// least one cycle later; requests arriving while busy are dropped.
module pgw_step_unit
    import pgw_pkg::*;
#(
    parameter int PA_W = 48
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_leaf,
    input  logic [63:0] req_base,
    input  logic [2:0]  req_level,
    input  logic        req_odd,
    input  logic [63:0] fault_va,
    input  logic [32:0] cfg_lo,
    input  logic [23:0] cfg_hi,
    output logic        busy,
    output logic        done,
    output logic [63:0] dir_result,
    output logic [63:0] even_entry,
    output logic [63:0] odd_entry,
    output logic [6:0]  leaf_ps,
    output logic        mem_req_valid,
    output logic [63:0] mem_req_addr,
    input  logic        mem_rsp_valid,
    input  logic [63:0] mem_rsp_data
);
    localparam int DW = 64;
    localparam logic [DW-1:0] PA_MASK = (PA_W >= DW) ? '1 : ((DW'(1) << PA_W) - DW'(1));

    state_t        state;
    dest_t         dest;
    logic [DW-1:0] base_m;
    logic          huge;
    logic          level_ok;
    logic          need_read;
    logic          accept;
    logic          rsp_take;
    logic [2:0]    geom_level;
    geom_t         geom;
    logic [1:0]    size_code;
    logic [DW-1:0] rd_addr;
    logic [DW-1:0] dir_tagged;
    logic [DW-1:0] huge_val;
    logic [6:0]    huge_ps;

    // request classification
    always_comb begin
        base_m     = req_base & PA_MASK;
        huge       = req_leaf ? base_m[HUGE_BIT] : req_base[HUGE_BIT];
        level_ok   = (req_level >= 3'd1) && (req_level <= 3'd4);
        need_read  = req_leaf ? !huge : (level_ok && !huge);
        geom_level = req_leaf ? (huge ? {1'b0, base_m[LVL_LSB +: LVL_W]} : 3'd0) : req_level;
        accept     = req_valid && (state == ST_IDLE);
        rsp_take   = (state == ST_WAIT) && !mem_req_valid && mem_rsp_valid;
    end

    pgw_geom_sel u_geom (
        .cfg_lo    (cfg_lo),
        .cfg_hi    (cfg_hi),
        .level     (geom_level),
        .geom      (geom),
        .size_code (size_code)
    );

    pgw_addr_gen #(.DW(DW)) u_addr (
        .base_m    (base_m),
        .fault_va  (fault_va),
        .geom      (geom),
        .size_code (size_code),
        .is_leaf   (req_leaf),
        .odd       (req_odd),
        .addr      (rd_addr)
    );

    pgw_huge_xform #(.DW(DW)) u_huge (
        .base_raw   (req_base),
        .base_m     (base_m),
        .req_level  (req_level),
        .geom       (geom),
        .odd        (req_odd),
        .dir_tagged (dir_tagged),
        .leaf_val   (huge_val),
        .leaf_ps    (huge_ps)
    );

    // control state, read issue and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            dest          <= DST_DIR;
            done          <= 1'b0;
            mem_req_valid <= 1'b0;
            mem_req_addr  <= '0;
            dir_result    <= '0;
            even_entry    <= '0;
            odd_entry     <= '0;
            leaf_ps       <= '0;
        end else begin
            done          <= 1'b0;
            mem_req_valid <= 1'b0;
            if (accept) begin
                if (need_read) begin
                    state         <= ST_WAIT;
                    mem_req_valid <= 1'b1;
                    mem_req_addr  <= rd_addr;
                    dest          <= !req_leaf ? DST_DIR : (req_odd ? DST_ODD : DST_EVEN);
                    if (req_leaf) begin
                        leaf_ps <= {1'b0, geom.pos};
                    end
                end else begin
                    done <= 1'b1;
                    if (!req_leaf) begin
                        dir_result <= level_ok ? dir_tagged : req_base;
                    end else begin
                        leaf_ps <= huge_ps;
                        if (req_odd) odd_entry  <= huge_val;
                        else         even_entry <= huge_val;
                    end
                end
            end else if (rsp_take) begin
                state <= ST_IDLE;
                done  <= 1'b1;
                case (dest)
                    DST_EVEN: even_entry <= mem_rsp_data & PA_MASK;
                    DST_ODD:  odd_entry  <= mem_rsp_data & PA_MASK;
                    default:  dir_result <= mem_rsp_data & PA_MASK;
                endcase
            end
        end
    end

    assign busy = (state == ST_WAIT);

    // R11: a read request lasts exactly one cycle
    a_r11_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // R11: a request only exists while a read is outstanding
    a_r11_req_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> busy);

    // R11: a taken response completes the step on the next cycle
    a_r11_rsp_done: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_take |=> (done && !busy));

    // R9: read addresses stay inside the physical range
    a_r9_addr_masked: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> ((mem_req_addr & ~PA_MASK) == '0));

    // R4: an out-of-range level finishes without touching memory
    a_r4_bad_level_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_leaf && ((req_level == 3'd0) || (req_level > 3'd4)))
        |=> (!mem_req_valid && done));

    // R5: a huge directory entry finishes without touching memory
    a_r5_huge_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_leaf && req_base[HUGE_BIT] && (req_level != 3'd0) && (req_level <= 3'd4))
        |=> (!mem_req_valid && done));

    // R7: a huge leaf finishes without touching memory
    a_r7_huge_leaf_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_leaf && req_base[HUGE_BIT]) |=> (!mem_req_valid && done));
endmodule

// File: tb/sim_pgw_step_unit.sv
// sim_pgw_step_unit: scoreboard bench. The driver computes each expected
// item from the requirements and queues it; the monitor compares the read
// address and every result register as the design completes.
module sim_pgw_step_unit;
    localparam int PA_W = 48;
    localparam logic [63:0] M = (64'd1 << PA_W) - 64'd1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_leaf = 1'b0;
    logic [63:0] req_base = '0;
    logic [2:0]  req_level = '0;
    logic        req_odd = 1'b0;
    logic [63:0] fault_va = 64'h0000_7ABC_DEF1_3579;
    logic [32:0] cfg_lo;
    logic [23:0] cfg_hi;
    logic        busy, done, mem_req_valid, mem_rsp_valid = 1'b0;
    logic [63:0] dir_result, even_entry, odd_entry, mem_req_addr, mem_rsp_data = '0;
    logic [6:0]  leaf_ps;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int code = 0;
    int gp[5] = '{12, 21, 30, 39, 44};
    int gw[5] = '{9, 9, 9, 9, 4};

    logic [63:0] m_dir = '0, m_even = '0, m_odd = '0;
    logic [6:0]  m_ps = '0;

    typedef struct {
        bit          rd;
        logic [63:0] addr;
        logic [63:0] dirv;
        logic [63:0] ev;
        logic [63:0] od;
        logic [6:0]  ps;
    } exp_t;
    exp_t  q[$];
    string qtag[$];
    bit    addr_seen = 1'b0;

    logic        mpend = 1'b0;
    logic [63:0] maddr = '0;

    always #2.5 clk = ~clk;

    pgw_step_unit #(.PA_W(PA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_leaf(req_leaf),
        .req_base(req_base), .req_level(req_level), .req_odd(req_odd),
        .fault_va(fault_va), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .busy(busy),
        .done(done), .dir_result(dir_result), .even_entry(even_entry),
        .odd_entry(odd_entry), .leaf_ps(leaf_ps), .mem_req_valid(mem_req_valid),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    always_comb begin
        cfg_lo = {5'(gw[2]), 6'(gp[2]), 5'(gw[1]), 6'(gp[1]), 5'(gw[0]), 6'(gp[0])};
        cfg_hi = {2'(code), 5'(gw[4]), 6'(gp[4]), 5'(gw[3]), 6'(gp[3])};
    end

    function automatic logic [63:0] memfn(input logic [63:0] a);
        return 64'hDEAD_0000_0000_0000 ^ (a << 3) ^ 64'h0000_0000_1357_9BDF;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // memory model: answer each request one cycle later
    always @(negedge clk) begin
        if (mem_rsp_valid) mem_rsp_valid = 1'b0;
        if (mpend) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = memfn(maddr);
            mpend = 1'b0;
        end
        if (mem_req_valid) begin
            mpend = 1'b1;
            maddr = mem_req_addr;
        end
    end

    // monitor: compare addresses and completions against the queue
    always @(negedge clk) begin
        if (rst_n && mem_req_valid) begin
            if (q.size() == 0 || !q[0].rd) begin
                chk("R11 unexpected read", mem_req_addr, 64'hx);
            end else begin
                chk({qtag[0], " address"}, mem_req_addr, q[0].addr);
                addr_seen = 1'b1;
            end
        end
        if (rst_n && done) begin
            if (q.size() == 0) begin
                chk("R11 unexpected done", 64'(done), 64'd0);
            end else begin
                if (q[0].rd) chk({qtag[0], " read issued"}, 64'(addr_seen), 64'd1);
                else         chk({qtag[0], " no read"}, 64'(addr_seen), 64'd0);
                chk({qtag[0], " dir_result"}, dir_result, q[0].dirv);
                chk({qtag[0], " even_entry"}, even_entry, q[0].ev);
                chk({qtag[0], " odd_entry"}, odd_entry, q[0].od);
                chk({qtag[0], " leaf_ps"}, 64'(leaf_ps), 64'(q[0].ps));
                void'(q.pop_front());
                void'(qtag.pop_front());
                addr_seen = 1'b0;
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // expected-value model built from the requirements
    task automatic model(input bit leaf, input logic [63:0] base, input int lvl,
                         input bit odd, input string tag);
        exp_t e;
        logic [63:0] b, idx, a;
        int sh, p, w, fl;
        sh = (code + 1) * 3;
        e.rd = 1'b0;
        e.addr = '0;
        if (!leaf) begin
            if (lvl == 0 || lvl > 4) begin
                m_dir = base;
            end else if (base[6]) begin
                m_dir = base;
                if (base[14:13] == 2'b00) m_dir[14:13] = 2'(lvl);
            end else begin
                idx = (fault_va >> gp[lvl]) & ((64'd1 << gw[lvl]) - 1);
                a = (base & M) | (idx << sh);
                e.rd = 1'b1; e.addr = a;
                m_dir = memfn(a) & M;
            end
        end else begin
            b = base & M;
            if (b[6]) begin
                fl = int'(b[14:13]);
                p = gp[fl]; w = gw[fl];
                b[14:13] = 2'b00;
                b[6] = 1'b0;
                if (b[12]) begin b[12] = 1'b0; b[6] = 1'b1; end
                m_ps = 7'(p + w - 1);
                if (odd) m_odd = b + (64'd1 << (p + w - 1));
                else     m_even = b;
            end else begin
                idx = ((fault_va >> gp[0]) & ((64'd1 << gw[0]) - 1)) & ~64'd1;
                a = b | ((idx + 64'(odd)) << sh);
                e.rd = 1'b1; e.addr = a;
                m_ps = 7'(gp[0]);
                if (odd) m_odd = memfn(a) & M;
                else     m_even = memfn(a) & M;
            end
        end
        e.dirv = m_dir; e.ev = m_even; e.od = m_odd; e.ps = m_ps;
        q.push_back(e);
        qtag.push_back(tag);
    endtask

    task automatic drive(input bit leaf, input logic [63:0] base, input int lvl,
                         input bit odd, input string tag);
        while (busy) @(negedge clk);
        model(leaf, base, lvl, odd, tag);
        req_valid = 1'b1; req_leaf = leaf; req_base = base;
        req_level = 3'(lvl); req_odd = odd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic settle();
        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy", 64'(busy), 0);
        chk("R1 done", 64'(done), 0);
        chk("R1 mem_req_valid", 64'(mem_req_valid), 0);
        chk("R1 dir_result", dir_result, 0);
        chk("R1 even_entry", even_entry, 0);
        chk("R1 odd_entry", odd_entry, 0);
        chk("R1 leaf_ps", 64'(leaf_ps), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3: directory reads at each level with each entry size
        code = 0; drive(0, 64'h0000_0012_3400_0000, 1, 0, "R2 R3 level1 size0"); settle();
        code = 1; drive(0, 64'h0000_0045_6700_0000, 2, 0, "R2 R3 level2 size1"); settle();
        code = 2; drive(0, 64'h0000_0078_9000_0000, 3, 0, "R2 R3 level3 size2"); settle();
        code = 3; drive(0, 64'h0000_00AB_C000_0000, 4, 0, "R2 R3 level4 size3"); settle();
        // R9: base bits above the physical width are dropped
        code = 0; drive(0, 64'hFFFF_0011_0000_0000, 1, 0, "R9 dir masked base"); settle();

        // R4: bad levels return the base untouched
        drive(0, 64'hF0F0_1234_5678_9ABC & ~64'h40, 0, 0, "R4 level0"); settle();
        drive(0, 64'h8000_0000_0000_1000, 5, 0, "R4 level5"); settle();

        // R5: huge directory entries
        drive(0, 64'h0000_0003_0000_0040, 2, 0, "R5 huge tag written"); settle();
        drive(0, 64'h0000_0003_0000_4040, 3, 0, "R5 huge tag kept"); settle();

        // R6 R10: leaf halves of a normal table, odd fault index
        drive(1, 64'h0000_0055_0000_0000, 0, 0, "R6 R10 leaf even"); settle();
        code = 2;
        drive(1, 64'h0000_0055_0000_0000, 0, 1, "R6 R10 leaf odd"); settle();
        fault_va = 64'h0000_1234_5678_8000;
        code = 1;
        drive(1, 64'hABCD_0066_0000_0000, 0, 1, "R6 R9 leaf odd masked"); settle();

        // R7 R8: huge leaf entries
        drive(1, 64'h0000_0040_0000_5040, 0, 0, "R7 huge even global"); settle();
        drive(1, 64'h0000_0040_0000_5040, 0, 1, "R8 huge odd global"); settle();
        drive(1, 64'h0000_0100_0000_6000 | 64'h40, 0, 1, "R7 R8 huge odd level3"); settle();
        drive(1, 64'h0000_0100_0000_2040, 0, 0, "R7 huge even level1"); settle();

        // R11: request while busy is ignored
        code = 0;
        drive(0, 64'h0000_0099_0000_0000, 1, 0, "R11 busy drop");
        req_valid = 1'b1; req_leaf = 1'b0; req_level = 3'd0;
        req_base = 64'h1111_2222_3333_4444;
        chk("R11 busy during read", 64'(busy), 1);
        @(negedge clk);
        req_valid = 1'b0;
        settle();
        chk("R11 idle after", 64'(busy), 0);
        chk("R11 queue drained", 64'(q.size()), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule